// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block collects every reason a chip may need to restart and turns them into two reset outputs: a system reset for the peripherals and a CPU reset for the processor core. The sources are an asynchronous power-on reset, an external reset pin, a programmable match on a 4-bit input port, a watchdog request, an oscillator-stopped indication and entry into sleep mode. The external pin and the port match pass through a digital debounce while the clock runs. During sleep they act without debounce and wake the chip.

The port match is set by an option register that holds a 2-bit code per pin. The four per-pin terms are combined by AND or by OR, and a build parameter picks which. A sleep request is accepted only after software has set a separate sleep-enable latch. Waking clears the sleep flag but leaves that latch set, so software can tell a wake-up from a power-up. The CPU reset is stretched by a long oscillator-settling delay after power-up, after a wake and after an oscillator stop. The oscillator-stopped input is ignored while that delay runs.

Top module: `reset_hub`

## Requirements
- R1: Each port pin n has a 2-bit code in option bits [2n+1:2n]. Code 0 gives a constant 0, code 1 gives the pin level, code 2 gives the inverted pin level and code 3 gives a constant 1.
- R2: With OR_MODE=0 the four pin terms are ANDed into the match, so an option value of 8'hFF always matches. With OR_MODE=1 the terms are ORed, so an option value of 8'h00 never matches.
- R3: While the chip is awake, the reset pin or the port match must be high for DEB_CYCLES consecutive clock edges before it causes a reset. A shorter pulse has no effect.
- R4: While the chip sleeps, a high reset pin wakes it at the next clock edge with no debounce. A port match wakes it the same way only when the wake option bit is 1. With the wake option bit at 0, a match leaves the chip asleep.
- R5: Every reset source asserts both sys_rst and cpu_rst. sys_rst stays high for SYS_HOLD cycles after the last cycle in which a source was present.
- R6: cpu_rst stays high for CPU_DELAY cycles after power-on release, after a wake from sleep and after an oscillator stop.
- R7: Power-on reset clears the option registers and the sleep-enable latch. Watchdog, pin, port-match, oscillator and sleep resets leave them unchanged.
- R8: A sleep request is ignored while sleep_en is 0. An accepted sleep request sets sleeping and asserts both resets. A wake clears sleeping and keeps sleep_en at 1.
- R9: The oscillator-stopped input causes no reset while osc_inh is 1 or while the CPU delay runs. Every system reset clears osc_inh.
- R10: A one-cycle watchdog request gives a reset of exactly SYS_HOLD cycles on both outputs and does not start the CPU delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, active high |
| port_in | input | NPIN | Input port levels for the match reset |
| wdog_req | input | 1 | Watchdog reset request |
| osc_stopped | input | 1 | Oscillator-stopped indication |
| opt_we | input | 1 | Write strobe for the option registers |
| opt_sel_d | input | 2*NPIN | Per-pin match codes to write |
| opt_wake_d | input | 1 | Sleep-wake-by-match option to write |
| slpen_we | input | 1 | Write strobe for the sleep-enable latch |
| slpen_d | input | 1 | Sleep-enable value to write |
| sleep_req | input | 1 | Request to enter sleep |
| oscinh_we | input | 1 | Write strobe for the oscillator-detector inhibit |
| oscinh_d | input | 1 | Inhibit value to write |
| sys_rst | output | 1 | System reset, active high |
| cpu_rst | output | 1 | CPU reset, active high |
| sleeping | output | 1 | Sleep flag |
| sleep_en | output | 1 | Sleep-enable latch |
| osc_inh | output | 1 | Oscillator-detector inhibit |
| opt_sel_q | output | 2*NPIN | Stored per-pin match codes |
| opt_wake_q | output | 1 | Stored wake-by-match option |

## Verification
The hardest behaviour to reach from the ports is the port-match decision itself. Its result is visible only as a reset that appears after a full debounce and then has to drain before the next setting can be tried. The bench builds one AND-mode and one OR-mode instance with short debounce and hold lengths. It then walks all 256 code settings against all 16 port values, and after each setting it restores a non-matching code and waits for the reset to clear. The wake-by-match path needs its own sequence: set the sleep-enable latch, enter sleep, load an always-matching code while asleep with the wake option off, and then turn the option on.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_PIN  = 2'd1,
    SEL_INV  = 2'd2,
    SEL_ONE  = 2'd3
  } sel_code_e;

  // Per-pin contribution to the port-match reset.
  function automatic logic sel_term(input sel_code_e code, input logic pin);
    logic t;
    case (code)
      SEL_ZERO: t = 1'b0;
      SEL_PIN:  t = pin;
      SEL_INV:  t = ~pin;
      default:  t = 1'b1;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/rsthub_match.sv
module rsthub_match
  import reset_hub_pkg::*;
#(
  parameter int unsigned NPIN    = 4,
  parameter bit          OR_MODE = 1'b0
) (
  input  logic [2*NPIN-1:0] sel,
  input  logic [NPIN-1:0]   pins,
  output logic              hit
);

  logic [NPIN-1:0] terms;

  for (genvar g = 0; g < NPIN; g++) begin : g_term
    assign terms[g] = sel_term(sel_code_e'(sel[2*g+1:2*g]), pins[g]);
  end

  if (OR_MODE) begin : g_or
    assign hit = |terms;
  end else begin : g_and
    assign hit = &terms;
  end

endmodule

// File: rtl/rsthub_debounce.sv
module rsthub_debounce #(
  parameter int unsigned CYCLES = 512
) (
  input  logic clk,
  input  logic por_n,
  input  logic din,
  output logic q
);

  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                     cnt <= '0;
    else if (!din)                  cnt <= '0;
    else if (cnt != CW'(CYCLES))    cnt <= cnt + CW'(1);
  end

  assign q = (cnt == CW'(CYCLES));

  AST_DEB_DROP: assert property (@(posedge clk) disable iff (!por_n)
    !din |=> !q); // R3
  AST_DEB_RISE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(q) |-> $past(din)); // R3

endmodule

// File: rtl/rsthub_hold.sv
module rsthub_hold #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic load,
  input  logic run,
  output logic busy
);

  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 cnt <= CW'(LEN);
    else if (load)              cnt <= CW'(LEN);
    else if (run && cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!por_n)
    load |=> busy); // R5
  AST_HOLD_STEP: assert property (@(posedge clk) disable iff (!por_n)
    busy && run && !load |=> cnt == $past(cnt) - CW'(1)); // R6

endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter int unsigned NPIN       = 4,
  parameter int unsigned DEB_CYCLES = 512,
  parameter int unsigned SYS_HOLD   = 16,
  parameter int unsigned CPU_DELAY  = 32768,
  parameter bit          OR_MODE    = 1'b0
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                rst_pin,
  input  logic [NPIN-1:0]     port_in,
  input  logic                wdog_req,
  input  logic                osc_stopped,
  input  logic                opt_we,
  input  logic [2*NPIN-1:0]   opt_sel_d,
  input  logic                opt_wake_d,
  input  logic                slpen_we,
  input  logic                slpen_d,
  input  logic                sleep_req,
  input  logic                oscinh_we,
  input  logic                oscinh_d,
  output logic                sys_rst,
  output logic                cpu_rst,
  output logic                sleeping,
  output logic                sleep_en,
  output logic                osc_inh,
  output logic [2*NPIN-1:0]   opt_sel_q,
  output logic                opt_wake_q
);

  localparam int unsigned SELW = 2 * NPIN;

  logic [SELW-1:0] opt_sel_r;
  logic            opt_wake_r;
  logic            slpen_r;
  logic            sleep_r;
  logic            inh_r;

  // Named internal events
  logic match_hit;
  logic pin_deb;
  logic match_deb;
  logic wake_evt;
  logic sleep_go;
  logic osc_fault;
  logic src_any;
  logic sys_busy;
  logic cpu_busy;

  rsthub_match #(.NPIN(NPIN), .OR_MODE(OR_MODE)) u_match (
    .sel  (opt_sel_r),
    .pins (port_in),
    .hit  (match_hit)
  );

  // No clock in sleep: the debouncers are held cleared.
  rsthub_debounce #(.CYCLES(DEB_CYCLES)) u_deb_pin (
    .clk   (clk),
    .por_n (por_n),
    .din   (rst_pin & ~sleep_r),
    .q     (pin_deb)
  );

  rsthub_debounce #(.CYCLES(DEB_CYCLES)) u_deb_match (
    .clk   (clk),
    .por_n (por_n),
    .din   (match_hit & ~sleep_r),
    .q     (match_deb)
  );

  assign wake_evt  = sleep_r & (rst_pin | (opt_wake_r & match_hit));
  assign sleep_go  = sleep_req & slpen_r & ~sleep_r;
  assign osc_fault = osc_stopped & ~inh_r & ~cpu_busy & ~sleep_r;
  assign src_any   = pin_deb | match_deb | wdog_req | osc_fault | sleep_r | wake_evt;

  rsthub_hold #(.LEN(SYS_HOLD)) u_sys_hold (
    .clk   (clk),
    .por_n (por_n),
    .load  (src_any),
    .run   (1'b1),
    .busy  (sys_busy)
  );

  rsthub_hold #(.LEN(CPU_DELAY)) u_cpu_hold (
    .clk   (clk),
    .por_n (por_n),
    .load  (wake_evt | osc_fault),
    .run   (~sleep_r),
    .busy  (cpu_busy)
  );

  // Option registers and sleep-enable: power-on reset only.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      opt_sel_r  <= '0;
      opt_wake_r <= 1'b0;
    end else if (opt_we) begin
      opt_sel_r  <= opt_sel_d;
      opt_wake_r <= opt_wake_d;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         slpen_r <= 1'b0;
    else if (slpen_we)  slpen_r <= slpen_d;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         sleep_r <= 1'b0;
    else if (wake_evt)  sleep_r <= 1'b0;
    else if (sleep_go)  sleep_r <= 1'b1;
  end

  // Detector inhibit: cleared by every system reset.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          inh_r <= 1'b0;
    else if (sys_busy)   inh_r <= 1'b0;
    else if (oscinh_we)  inh_r <= oscinh_d;
  end

  assign sys_rst    = sys_busy;
  assign cpu_rst    = sys_busy | cpu_busy;
  assign sleeping   = sleep_r;
  assign sleep_en   = slpen_r;
  assign osc_inh    = inh_r;
  assign opt_sel_q  = opt_sel_r;
  assign opt_wake_q = opt_wake_r;

  AST_SRC_BOTH: assert property (@(posedge clk) disable iff (!por_n)
    src_any |=> sys_rst && cpu_rst); // R5
  AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sleeping) |-> $past(slpen_r)); // R8
  AST_WAKE_KEEPS_EN: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sleeping) |-> sleep_en); // R8
  AST_OPT_HELD: assert property (@(posedge clk) disable iff (!por_n)
    !opt_we |=> $stable(opt_sel_q) && $stable(opt_wake_q)); // R7
  AST_INH_CLEARED: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> !osc_inh); // R9
  AST_FALL_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> !$past(src_any)); // R5

endmodule

// File: tb/test_reset_hub.sv
module test_reset_hub;

  localparam int DEB  = 3;
  localparam int HOLD = 4;
  localparam int DLY  = 40;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       rst_pin = 1'b0;
  logic [3:0] port_in = '0;
  logic       wdog_req = 1'b0;
  logic       osc_stopped = 1'b0;
  logic       opt_we = 1'b0;
  logic [7:0] opt_sel_d = '0;
  logic       opt_wake_d = 1'b0;
  logic       slpen_we = 1'b0;
  logic       slpen_d = 1'b0;
  logic       sleep_req = 1'b0;
  logic       oscinh_we = 1'b0;
  logic       oscinh_d = 1'b0;

  logic       sys_rst, cpu_rst, sleeping, sleep_en, osc_inh, opt_wake_q;
  logic [7:0] opt_sel_q;
  logic       o_sys, o_cpu, o_slp, o_sen, o_inh, o_wake;
  logic [7:0] o_sel;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  reset_hub #(.NPIN(4), .DEB_CYCLES(DEB), .SYS_HOLD(HOLD), .CPU_DELAY(DLY), .OR_MODE(1'b0)) i_reset_hub (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .port_in(port_in), .wdog_req(wdog_req),
    .osc_stopped(osc_stopped), .opt_we(opt_we), .opt_sel_d(opt_sel_d), .opt_wake_d(opt_wake_d),
    .slpen_we(slpen_we), .slpen_d(slpen_d), .sleep_req(sleep_req), .oscinh_we(oscinh_we),
    .oscinh_d(oscinh_d), .sys_rst(sys_rst), .cpu_rst(cpu_rst), .sleeping(sleeping),
    .sleep_en(sleep_en), .osc_inh(osc_inh), .opt_sel_q(opt_sel_q), .opt_wake_q(opt_wake_q));

  reset_hub #(.NPIN(4), .DEB_CYCLES(DEB), .SYS_HOLD(HOLD), .CPU_DELAY(DLY), .OR_MODE(1'b1)) i_reset_hub_or (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .port_in(port_in), .wdog_req(wdog_req),
    .osc_stopped(osc_stopped), .opt_we(opt_we), .opt_sel_d(opt_sel_d), .opt_wake_d(opt_wake_d),
    .slpen_we(slpen_we), .slpen_d(slpen_d), .sleep_req(sleep_req), .oscinh_we(oscinh_we),
    .oscinh_d(oscinh_d), .sys_rst(o_sys), .cpu_rst(o_cpu), .sleeping(o_slp),
    .sleep_en(o_sen), .osc_inh(o_inh), .opt_sel_q(o_sel), .opt_wake_q(o_wake));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Count consecutive samples (current one first) with the chosen output high.
  task automatic count_high(input bit use_cpu, output int n);
    n = 0;
    while ((use_cpu ? cpu_rst : sys_rst) && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic int expect_hit(input int s, input int v, input bit orm);
    int acc;
    acc = orm ? 0 : 1;
    for (int i = 0; i < 4; i++) begin
      int lo, hi, b, t;
      lo = (s / (1 << (2 * i))) % 2;
      hi = (s / (1 << (2 * i + 1))) % 2;
      b  = (v / (1 << i)) % 2;
      if (lo == hi) t = hi;
      else t = hi ? (1 - b) : b;
      acc = orm ? (acc + t > 0 ? 1 : 0) : acc * t;
    end
    return acc;
  endfunction

  task automatic write_opt(input int s, input bit wk);
    opt_sel_d = 8'(s); opt_wake_d = wk; opt_we = 1'b1;
    @(negedge clk);
    opt_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int seen;
    // ---- power-on reset state (R7, R5)
    nclk(4);
    chk("R5 por sys_rst", sys_rst, 1);
    chk("R5 por cpu_rst", cpu_rst, 1);
    chk("R8 por sleeping", sleeping, 0);
    chk("R7 por sleep_en", sleep_en, 0);
    chk("R7 por opt_sel", opt_sel_q, 0);
    por_n = 1'b1;
    #1;
    count_high(1'b1, n);
    chk("R6 cpu delay after power-on", n, DLY);

    // ---- exhaustive match sweep, AND and OR (R1, R2, R3)
    for (int s = 0; s < 256; s++) begin
      for (int v = 0; v < 16; v++) begin
        port_in = 4'(v);
        write_opt(s, 1'b0);
        nclk(DEB + 2);
        chk($sformatf("R1 R2 and-mode sel=%0h port=%0h", s, v), sys_rst, expect_hit(s, v, 1'b0));
        chk($sformatf("R1 R2 or-mode sel=%0h port=%0h", s, v), o_sys, expect_hit(s, v, 1'b1));
        write_opt(0, 1'b0);
        nclk(HOLD + DEB + 3);
      end
    end
    port_in = '0;

    // ---- watchdog reset keeps option state, clears inhibit (R10, R7, R9)
    write_opt(8'h55, 1'b1);
    slpen_d = 1'b1; slpen_we = 1'b1; oscinh_d = 1'b1; oscinh_we = 1'b1;
    @(negedge clk);
    slpen_we = 1'b0; oscinh_we = 1'b0;
    chk("R9 inhibit written", osc_inh, 1);
    wdog_req = 1'b1;
    @(negedge clk);
    wdog_req = 1'b0;
    chk("R10 cpu_rst with watchdog", cpu_rst, 1);
    count_high(1'b0, n);
    chk("R10 sys_rst length after watchdog", n, HOLD);
    chk("R10 no cpu delay after watchdog", cpu_rst, 0);
    chk("R7 opt_sel kept", opt_sel_q, 8'h55);
    chk("R7 opt_wake kept", opt_wake_q, 1);
    chk("R7 sleep_en kept", sleep_en, 1);
    chk("R9 inhibit cleared by reset", osc_inh, 0);

    // ---- oscillator detector: inhibit, delay, masking (R9, R6)
    oscinh_d = 1'b1; oscinh_we = 1'b1;
    @(negedge clk);
    oscinh_we = 1'b0;
    osc_stopped = 1'b1;
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (sys_rst) seen = 1;
    end
    osc_stopped = 1'b0;
    chk("R9 inhibited detector gives no reset", seen, 0);
    oscinh_d = 1'b0; oscinh_we = 1'b1;
    @(negedge clk);
    oscinh_we = 1'b0;
    osc_stopped = 1'b1;
    @(negedge clk);
    osc_stopped = 1'b0;
    n = 0;
    while (cpu_rst && n < 5000) begin
      n++;
      if (n == 5) osc_stopped = 1'b1;
      if (n == 8) osc_stopped = 1'b0;
      @(negedge clk);
    end
    chk("R6 R9 cpu delay after oscillator stop, no reload", n, DLY);

    // ---- pin debounce (R3, R5)
    rst_pin = 1'b1;
    nclk(DEB - 1);
    rst_pin = 1'b0;
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (sys_rst) seen = 1;
    end
    chk("R3 short pin pulse ignored", seen, 0);
    rst_pin = 1'b1;
    nclk(DEB);
    rst_pin = 1'b0;
    @(negedge clk);
    chk("R5 pin reset cpu_rst", cpu_rst, 1);
    count_high(1'b0, n);
    chk("R3 R5 debounced pin reset length", n, HOLD);

    // ---- sleep handshake (R8, R4)
    slpen_d = 1'b0; slpen_we = 1'b1;
    @(negedge clk);
    slpen_we = 1'b0; sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    nclk(3);
    chk("R8 sleep ignored without enable", sleeping, 0);
    chk("R8 no reset without enable", sys_rst, 0);
    slpen_d = 1'b1; slpen_we = 1'b1;
    @(negedge clk);
    slpen_we = 1'b0; sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk("R8 sleep entered", sleeping, 1);
    @(negedge clk);
    chk("R8 sleep asserts sys_rst", sys_rst, 1);
    chk("R8 sleep asserts cpu_rst", cpu_rst, 1);
    write_opt(8'hFF, 1'b0);
    nclk(5);
    chk("R4 match without wake option ignored", sleeping, 1);
    chk("R8 reset held in sleep", sys_rst, 1);
    write_opt(8'hFF, 1'b1);
    @(negedge clk);
    chk("R4 match wakes immediately", sleeping, 0);
    chk("R8 sleep_en kept after wake", sleep_en, 1);
    write_opt(0, 1'b0);
    count_high(1'b1, n);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    nclk(4);
    chk("R8 asleep again", sleeping, 1);
    rst_pin = 1'b1;
    @(negedge clk);
    rst_pin = 1'b0;
    chk("R4 pin wakes immediately", sleeping, 0);
    count_high(1'b1, n);
    chk("R6 cpu delay after wake", n, DLY);

    // ---- power-on clears options and sleep enable (R7)
    por_n = 1'b0;
    #1;
    chk("R7 por clears sleep_en", sleep_en, 0);
    chk("R7 por clears opt_sel", opt_sel_q, 0);
    chk("R7 por clears opt_wake", opt_wake_q, 0);
    @(negedge clk);
    por_n = 1'b1;
    nclk(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule